// File: doc/BRIEF.md
# Secure Configuration Store

This block is the configuration-memory controller of a small programmable logic device. It keeps four things in registers: an array of pattern words, one architecture word that sets up the device's output cells, a 64-bit user signature held as eight bytes, and a one-bit security cell. Storage behaves like erasable non-volatile cells. A program operation can only clear bits. The only way to return bits to 1 is a bulk erase, which resets every stored bit at once.

A host sends one command at a time through a valid/command/address/data interface. The block raises busy for a fixed number of cycles. It then pulses done for one cycle, and in that cycle the read data and error flag are valid. Once the security cell is programmed, the pattern array and the architecture word can no longer be programmed or read back. The signature stays readable and writable. A 16-bit checksum of everything stored, signature included, is always present at an output so the contents can be compared without reading them out.

Top module: `cfg_store`

## Requirements
- R1: After reset, busy_o, done_o, err_o and lock_o are 0 and rdata_o is 0. Every stored bit is 1, so with default parameters checksum_o is 16'h07E7.
- R2: A command is accepted on a clock edge where cmd_valid_i is 1 and busy_o is 0. Command codes are: 0 no-op, 1 program array word, 2 verify array word, 3 program architecture word, 4 program signature byte, 5 read signature byte, 6 set security cell, 7 bulk erase. busy_o is then 1 for BUSY_CYC cycles, followed by exactly one cycle of done_o. A cmd_valid_i pulse while busy_o is 1 is ignored.
- R3: Programming an array word stores old AND data_i. Bits can only go from 1 to 0.
- R4: While unlocked, verify returns the array word at addr_i on rdata_o, with err_o at 0, in the done cycle.
- R5: After the set-security command, lock_o is 1. Array programming, architecture programming and verify then leave storage unchanged, return rdata_o of 0, and raise err_o in the done cycle.
- R6: Signature program (AND into byte addr_i[2:0]) and signature read (byte zero-extended on rdata_o) work whether or not the block is locked.
- R7: Bulk erase sets every array, architecture and signature bit to 1 and clears lock_o. It is the only command that clears lock_o.
- R8: checksum_o is the sum modulo 2^16 of the array words in address order, then the architecture word, then signature bytes 0 to 7 zero-extended. It reflects a command's effect in that command's done cycle.
- R9: Programming the architecture word stores old AND data_i, and arch_o shows the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 3 | Command code |
| addr_i | input | ADDR_W | Array word address or signature byte index |
| data_i | input | DATA_W | Program data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read result, valid with done_o |
| err_o | output | 1 | Command blocked by lock, valid with done_o |
| lock_o | output | 1 | Security cell programmed |
| arch_o | output | DATA_W | Stored architecture word |
| checksum_o | output | CSUM_W | Running checksum of all stored data |

## Verification
The pattern array is programmed twice at one address with overlapping masks. The result is the AND of both, which separates a write-only-clears model from an overwrite. Reads at several addresses with distinct patterns check that addresses are decoded apart. Signature bytes 0 and 7 are written with complementary patterns and read back before and after locking. This shows that the lock gates only the array side and that the byte index is not reversed. A command sent while busy, array access while locked, and a bulk erase afterwards are each tracked through rdata_o, err_o and checksum_o, which exposes any lost or unwanted write.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_PROG   = 3'd1,
    CMD_VERIFY = 3'd2,
    CMD_ARCH   = 3'd3,
    CMD_SIGW   = 3'd4,
    CMD_SIGR   = 3'd5,
    CMD_LOCK   = 3'd6,
    CMD_ERASE  = 3'd7
  } cmd_e;
endpackage

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              exec_o,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept = cmd_valid_i && !busy_q;
  assign exec_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      cmd_o  <= CMD_NOP;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      done_q <= exec_o;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(BUSY_CYC - 1);
        cmd_o  <= cmd_e'(cmd_i);
        addr_o <= addr_i;
        data_o <= data_i;
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R2
  done_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R2
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && done_q));
  // R2
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
endmodule

// File: rtl/cfg_cells.sv
module cfg_cells
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int SIG_BYTES = 8,
  localparam int DEPTH    = 2 ** ADDR_W,
  localparam int SIDX_W   = $clog2(SIG_BYTES)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 exec_i,
  input  cmd_e                                 cmd_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [DATA_W-1:0]                    data_i,
  output logic [DEPTH-1:0][DATA_W-1:0]         mem_o,
  output logic [DATA_W-1:0]                    arch_o,
  output logic [SIG_BYTES-1:0][7:0]            sig_o,
  output logic                                 lock_o,
  output logic [DATA_W-1:0]                    rdata_o,
  output logic                                 err_o
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DATA_W-1:0]            arch_q;
  logic [SIG_BYTES-1:0][7:0]    sig_q;
  logic                         open_q;  // erased security cell = 1
  logic [DATA_W-1:0]            rdata_q;
  logic                         err_q;
  logic [SIDX_W-1:0]            sidx;

  assign sidx = addr_i[SIDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q   <= '1;
      arch_q  <= '1;
      sig_q   <= '1;
      open_q  <= 1'b1;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (exec_i) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
      unique case (cmd_i)
        CMD_PROG:   if (!open_q) err_q <= 1'b1;
                    else mem_q[addr_i] <= mem_q[addr_i] & data_i;
        CMD_VERIFY: if (!open_q) err_q <= 1'b1;
                    else rdata_q <= mem_q[addr_i];
        CMD_ARCH:   if (!open_q) err_q <= 1'b1;
                    else arch_q <= arch_q & data_i;
        CMD_SIGW:   sig_q[sidx] <= sig_q[sidx] & data_i[7:0];
        CMD_SIGR:   rdata_q <= DATA_W'(sig_q[sidx]);
        CMD_LOCK:   open_q <= 1'b0;
        CMD_ERASE: begin
          mem_q  <= '1;
          arch_q <= '1;
          sig_q  <= '1;
          open_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign mem_o   = mem_q;
  assign arch_o  = arch_q;
  assign sig_o   = sig_q;
  assign lock_o  = !open_q;
  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  logic [DEPTH*DATA_W-1:0] mem_flat;
  logic [SIG_BYTES*8-1:0]  sig_flat;
  logic                    erasing;
  assign mem_flat = mem_q;
  assign sig_flat = sig_q;
  assign erasing  = exec_i && (cmd_i == CMD_ERASE);

  // R3
  bits_clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erasing |=> ((mem_flat & ~$past(mem_flat)) == '0) &&
                 ((sig_flat & ~$past(sig_flat)) == '0) &&
                 ((arch_q & ~$past(arch_q)) == '0));
  // R5
  locked_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q && !erasing) |=> $stable(mem_flat) && $stable(arch_q));
  // R5
  locked_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !open_q && cmd_i == CMD_VERIFY) |=> (rdata_q == '0) && err_q);
  // R7
  unlock_by_erase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_q) |-> $past(erasing));
endmodule

// File: rtl/cfg_csum.sv
module cfg_csum #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 16,
  parameter int SIG_BYTES = 8,
  parameter int CSUM_W    = 16
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0]            arch_i,
  input  logic [SIG_BYTES-1:0][7:0]    sig_i,
  output logic [CSUM_W-1:0]            sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < DEPTH; i++) sum_o = sum_o + CSUM_W'(mem_i[i]);
    sum_o = sum_o + CSUM_W'(arch_i);
    for (int j = 0; j < SIG_BYTES; j++) sum_o = sum_o + CSUM_W'(sig_i[j]);
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int SIG_BYTES = 8,
  parameter int CSUM_W    = 16,
  parameter int BUSY_CYC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              lock_o,
  output logic [DATA_W-1:0] arch_o,
  output logic [CSUM_W-1:0] checksum_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic                         exec;
  cmd_e                         cmd_q;
  logic [ADDR_W-1:0]            addr_q;
  logic [DATA_W-1:0]            data_q;
  logic [DEPTH-1:0][DATA_W-1:0] mem;
  logic [SIG_BYTES-1:0][7:0]    sig;

  cfg_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) u_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i, .addr_i, .data_i,
    .busy_o, .done_o, .exec_o(exec), .cmd_o(cmd_q), .addr_o(addr_q),
    .data_o(data_q)
  );

  cfg_cells #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_BYTES(SIG_BYTES)) u_cells (
    .clk_i, .rst_ni, .exec_i(exec), .cmd_i(cmd_q), .addr_i(addr_q),
    .data_i(data_q), .mem_o(mem), .arch_o, .sig_o(sig), .lock_o,
    .rdata_o, .err_o
  );

  cfg_csum #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SIG_BYTES(SIG_BYTES),
             .CSUM_W(CSUM_W)) u_csum (
    .mem_i(mem), .arch_i(arch_o), .sig_i(sig), .sum_o(checksum_o)
  );

  // R5
  lock_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> lock_o);
endmodule

// File: tb/cfg_store_bench.sv
module cfg_store_bench;
  localparam int BUSY_CYC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = '0;
  logic [3:0]  addr = '0;
  logic [15:0] data = '0;
  logic        busy_o, done_o, err_o, lock_o;
  logic [15:0] rdata_o, arch_o, checksum_o;

  int n_tests = 0;
  int n_fail = 0;
  logic [15:0] r_rdata;
  logic        r_err;

  always #2 clk = ~clk;

  cfg_store u_cfg_store (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .addr_i(addr), .data_i(data), .busy_o, .done_o, .rdata_o, .err_o,
    .lock_o, .arch_o, .checksum_o
  );

  // behavioural reference model
  logic [15:0] m_mem[16];
  logic [15:0] m_arch;
  logic [7:0]  m_sig[8];
  bit          m_open;
  int          m_left;
  bit          m_done;
  logic [15:0] m_rdata;
  bit          m_err;
  int          p_cmd, p_addr;
  logic [15:0] p_data;

  function automatic logic [15:0] m_csum();
    int s = 0;
    foreach (m_mem[i]) s += int'(m_mem[i]);
    s += int'(m_arch);
    foreach (m_sig[j]) s += int'(m_sig[j]);
    return 16'(s);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
      foreach (m_sig[j]) m_sig[j] = 8'hFF;
      m_arch = 16'hFFFF; m_open = 1; m_left = 0; m_done = 0;
      m_rdata = 0; m_err = 0;
    end else begin
      m_done = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          m_done = 1; m_rdata = 0; m_err = 0;
          case (p_cmd)
            1: if (!m_open) m_err = 1; else m_mem[p_addr] &= p_data;
            2: if (!m_open) m_err = 1; else m_rdata = m_mem[p_addr];
            3: if (!m_open) m_err = 1; else m_arch &= p_data;
            4: m_sig[p_addr % 8] &= p_data[7:0];
            5: m_rdata = {8'h00, m_sig[p_addr % 8]};
            6: m_open = 0;
            7: begin
              foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
              foreach (m_sig[j]) m_sig[j] = 8'hFF;
              m_arch = 16'hFFFF; m_open = 1;
            end
            default: ;
          endcase
        end
      end else if (cmd_valid) begin
        m_left = BUSY_CYC; p_cmd = int'(cmd); p_addr = int'(addr); p_data = data;
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "busy", 32'(busy_o), 32'(m_left > 0));
      chk("R2", "done", 32'(done_o), 32'(m_done));
      chk("R5", "lock", 32'(lock_o), 32'(!m_open));
      chk("R9", "arch", 32'(arch_o), 32'(m_arch));
      chk("R8", "checksum", 32'(checksum_o), 32'(m_csum()));
      if (m_done) begin
        chk("R4", "rdata", 32'(rdata_o), 32'(m_rdata));
        chk("R5", "err", 32'(err_o), 32'(m_err));
      end
    end
  end

  task automatic run(input int c, input int a, input int d);
    @(negedge clk);
    cmd_valid = 1; cmd = 3'(c); addr = 4'(a); data = 16'(d);
    @(negedge clk);
    cmd_valid = 0;
    while (!done_o) @(negedge clk);
    r_rdata = rdata_o; r_err = err_o;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy_o), 0);
    chk("R1", "done", 32'(done_o), 0);
    chk("R1", "lock", 32'(lock_o), 0);
    chk("R1", "rdata", 32'(rdata_o), 0);
    chk("R1", "checksum", 32'(checksum_o), 32'h07E7);

    // R3 two overlapping programs give the AND
    run(1, 3, 16'hF0F0);
    run(1, 3, 16'h0FFF);
    run(2, 3, 0);
    chk("R3", "and result", 32'(r_rdata), 32'h00F0);

    // R4 distinct addresses
    run(1, 0, 16'h1234);
    run(1, 15, 16'hBEEF);
    run(2, 0, 0);
    chk("R4", "word0", 32'(r_rdata), 32'h1234);
    run(2, 15, 0);
    chk("R4", "word15", 32'(r_rdata), 32'hBEEF);
    chk("R4", "err", 32'(r_err), 0);

    // R9 architecture word
    run(3, 0, 16'hA5C3);
    chk("R9", "arch", 32'(arch_o), 32'hA5C3);

    // R6 signature bytes
    run(4, 0, 8'h5A);
    run(4, 7, 8'hA5);
    run(5, 0, 0);
    chk("R6", "sig0", 32'(r_rdata), 32'h005A);
    run(5, 7, 0);
    chk("R6", "sig7", 32'(r_rdata), 32'h00A5);

    // R2 command during busy is dropped
    @(negedge clk);
    cmd_valid = 1; cmd = 3'd1; addr = 4'd5; data = 16'h0000;
    @(negedge clk);
    cmd = 3'd1; addr = 4'd6; data = 16'h0000;
    @(negedge clk);
    cmd_valid = 0;
    while (!done_o) @(negedge clk);
    run(2, 6, 0);
    chk("R2", "ignored prog", 32'(r_rdata), 32'hFFFF);

    // R5 lock
    run(6, 0, 0);
    chk("R5", "lock_o", 32'(lock_o), 1);
    run(2, 3, 0);
    chk("R5", "verify rdata", 32'(r_rdata), 0);
    chk("R5", "verify err", 32'(r_err), 1);
    run(1, 4, 16'h0000);
    chk("R5", "prog err", 32'(r_err), 1);
    run(3, 0, 16'h0000);
    chk("R5", "arch kept", 32'(arch_o), 32'hA5C3);
    run(6, 0, 0);
    chk("R7", "lock stays", 32'(lock_o), 1);

    // R6 signature while locked
    run(5, 7, 0);
    chk("R6", "locked sig7", 32'(r_rdata), 32'h00A5);
    chk("R6", "locked sig err", 32'(r_err), 0);
    run(4, 1, 8'h0F);
    run(5, 1, 0);
    chk("R6", "locked sig1", 32'(r_rdata), 32'h000F);

    // R7 bulk erase
    run(7, 0, 0);
    chk("R7", "unlock", 32'(lock_o), 0);
    chk("R7", "checksum", 32'(checksum_o), 32'h07E7);
    run(2, 3, 0);
    chk("R7", "word3", 32'(r_rdata), 32'hFFFF);
    run(5, 0, 0);
    chk("R7", "sig0", 32'(r_rdata), 32'h00FF);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule